// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Format Select and Flow Gating

This block turns parallel bytes into asynchronous serial frames on a single output line. A frame opens with a low start bit, carries the data bits least-significant first, optionally appends a parity bit, and closes with one high stop bit. The number of data bits (the full byte or one fewer) and the parity mode (none, odd, even) are sampled from the configuration pins at the moment a byte is accepted, so the format can change from one frame to the next.

Bytes enter through a valid/ready handshake and are held in a single shift register for the whole frame. Bit timing comes from a baud tick that pulses at 16 times the bit rate; every bit lasts exactly 16 ticks. Two independent conditions hold back the start of a new frame: the hardware clear-to-send input, and a software pause state that a companion receiver sets when it has seen an XOFF character and clears when it has seen XON. Neither stops a frame that has already begun.

The frame controller has five states: `ST_IDLE` (line high, waiting), `ST_START` (start bit), `ST_DATA` (data bits), `ST_PARITY` (parity bit) and `ST_STOP` (stop bit). Its transitions are: `ST_IDLE`->`ST_START` on an accepted byte; `ST_START`->`ST_DATA` at the end of the bit; `ST_DATA`->`ST_DATA` after each data bit but the last; `ST_DATA`->`ST_PARITY` after the last data bit when parity is on; `ST_DATA`->`ST_STOP` after the last data bit when parity is off; `ST_PARITY`->`ST_STOP` and `ST_STOP`->`ST_IDLE` at the end of their bits.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset the serial line is 1 and, with clear-to-send high and no pause request, `in_ready` is 1.
- R2: A frame is a start bit of 0, then the data bits with bit 0 first, then (if enabled) the parity bit, then a stop bit of 1; the idle line is 1.
- R3: With `cfg_len8` = 1 all 8 data bits are sent; with `cfg_len8` = 0 only bits 0 to 6 are sent and bit 7 of the byte has no effect on the frame.
- R4: `cfg_parity` encodes 2'b00 = none, 2'b01 = odd, 2'b10 = even, 2'b11 = none; with odd the count of 1s over the sent data bits plus the parity bit is odd, with even it is even.
- R5: The byte, length and parity mode are captured when the handshake completes; changing `cfg_len8`, `cfg_parity` or `in_data` during a frame does not alter that frame.
- R6: Every bit lasts exactly 16 `baud_tick` pulses counted from the accepting clock edge; `in_ready` is 0 up to the 16*F-1th tick and may rise at the 16*Fth tick edge, F being the frame length in bits.
- R7: While `cts` is 0 no new frame starts: the line stays 1 and `in_ready` is 0 even with `in_valid` held high.
- R8: A pulse on `xoff_seen` sets the pause state from the next cycle; a pulse on `xon_seen` clears it; when both are high in the same cycle the pause state is set.
- R9: A frame in progress always completes, whatever `cts`, `xoff_seen` or `xon_seen` do during it.
- R10: `in_ready` is 1 exactly when the controller is idle, the pause state is clear and `cts` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_parity | input | 2 | Parity mode (see R4) |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cts | input | 1 | Clear-to-send, 1 = peer may receive |
| xoff_seen | input | 1 | Pulse: companion receiver saw XOFF, pause |
| xon_seen | input | 1 | Pulse: companion receiver saw XON, resume |
| tx_line | output | 1 | Serial output line |

## Verification
Two functions can land in one cycle: a pause request on `xoff_seen` arriving on the very clock edge that completes a handshake, and a pause and a resume request arriving together. The first is provoked by raising `xoff_seen` in the same cycle as `in_valid` while `in_ready` is high; the bench expects the byte to be taken and sent as a whole, correct frame and `in_ready` to stay low at the end of the stop bit because the pause now holds. The second is provoked by pulsing both inputs together while idle, and it is judged by `in_ready` staying low and the line staying high until a lone resume arrives.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // Frame controller states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    // Parity mode encoding on the configuration pins
    typedef enum logic [1:0] {
        PAR_OFF  = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_OFF2 = 2'b11
    } par_mode_e;

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic bit_done
);
    localparam int CW = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

    logic [CW-1:0] cnt_q;

    assign bit_done = tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= bit_done ? '0 : cnt_q + 1'b1;
        end
    end

    // R6
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(cnt_q));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/tx_flow_gate.sv
module tx_flow_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_req,
    input  logic resume_req,
    input  logic cts,
    output logic paused,
    output logic may_start
);
    logic paused_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paused_q <= 1'b0;
        end else if (pause_req) begin
            paused_q <= 1'b1;
        end else if (resume_req) begin
            paused_q <= 1'b0;
        end
    end

    assign paused    = paused_q;
    assign may_start = cts && !paused_q;

    // R8
    pause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |=> paused);

    // R8
    resume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_req && !pause_req) |=> !paused);

endmodule

// File: rtl/tx_parity_calc.sv
module tx_parity_calc
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              len_full,
    input  logic [1:0]        mode,
    output logic              par_bit,
    output logic              par_on
);
    logic [DATA_W-1:0] used;

    // The top data bit only counts when the full length is selected
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_mask
            if (i == DATA_W - 1) begin : g_top
                assign used[i] = data[i] & len_full;
            end else begin : g_low
                assign used[i] = data[i];
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            PAR_ODD: begin
                par_on  = 1'b1;
                par_bit = ~(^used);
            end
            PAR_EVEN: begin
                par_on  = 1'b1;
                par_bit = ^used;
            end
            default: begin
                par_on  = 1'b0;
                par_bit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_len_full,
    input  logic              ld_par_bit,
    input  logic              ld_par_on,
    input  logic              bit_done,
    output logic              idle,
    output logic              tx_line
);
    localparam int IW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] IDX_FULL  = IW'(DATA_W - 1);
    localparam logic [IW-1:0] IDX_SHORT = IW'(DATA_W - 2);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q, shreg_d;
    logic [IW-1:0]     idx_q, idx_d;
    logic [IW-1:0]     last_q, last_d;
    logic              parb_q, parb_d;
    logic              paron_q, paron_d;
    logic              line_q, line_d;

    // Next state and datapath
    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        idx_d   = idx_q;
        last_d  = last_q;
        parb_d  = parb_q;
        paron_d = paron_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_START;
                    shreg_d = ld_data;
                    idx_d   = '0;
                    last_d  = ld_len_full ? IDX_FULL : IDX_SHORT;
                    parb_d  = ld_par_bit;
                    paron_d = ld_par_on;
                end
            end
            ST_START: begin
                if (bit_done) begin
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_done) begin
                    shreg_d = shreg_q >> 1;
                    idx_d   = idx_q + 1'b1;
                    if (idx_q == last_q) begin
                        state_d = paron_q ? ST_PARITY : ST_STOP;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_done) begin
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                if (bit_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Line level belonging to the state being entered
    always_comb begin
        unique case (state_d)
            ST_START:  line_d = 1'b0;
            ST_DATA:   line_d = shreg_d[0];
            ST_PARITY: line_d = parb_d;
            default:   line_d = 1'b1;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
            last_q  <= IDX_FULL;
            parb_q  <= 1'b0;
            paron_q <= 1'b0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            idx_q   <= idx_d;
            last_q  <= last_d;
            parb_q  <= parb_d;
            paron_q <= paron_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else begin
            line_q <= line_d;
        end
    end

    assign idle    = (state_q == ST_IDLE);
    assign tx_line = line_q;

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> tx_line);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |-> !tx_line);

    // R2
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> tx_line);

    // R9
    frame_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_STOP) |=> (state_q != ST_IDLE));

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (idx_q <= last_q));

    // R6
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_done && state_q != ST_IDLE) |=> $stable(state_q));

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cfg_len8,
    input  logic [1:0]        cfg_parity,
    input  logic              baud_tick,
    input  logic              cts,
    input  logic              xoff_seen,
    input  logic              xon_seen,
    output logic              tx_line
);
    logic idle;
    logic paused;
    logic may_start;
    logic accept;
    logic bit_done;
    logic par_bit;
    logic par_on;

    assign in_ready = idle && may_start;
    assign accept   = in_valid && in_ready;

    tx_flow_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_req  (xoff_seen),
        .resume_req (xon_seen),
        .cts        (cts),
        .paused     (paused),
        .may_start  (may_start)
    );

    tx_parity_calc #(.DATA_W(DATA_W)) u_par (
        .data     (in_data),
        .len_full (cfg_len8),
        .mode     (cfg_parity),
        .par_bit  (par_bit),
        .par_on   (par_on)
    );

    tx_bit_timer #(.OS_RATE(OS_RATE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .tick     (baud_tick),
        .bit_done (bit_done)
    );

    tx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .ld_data     (in_data),
        .ld_len_full (cfg_len8),
        .ld_par_bit  (par_bit),
        .ld_par_on   (par_on),
        .bit_done    (bit_done),
        .idle        (idle),
        .tx_line     (tx_line)
    );

    // R10
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (cts && !paused));

    // R7
    hold_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (!cts || paused)) |=> (idle && tx_line));

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !tx_line);

endmodule

// File: tb/tb_uart_tx_flow.sv
`timescale 1ns/1ps
module tb_uart_tx_flow;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       cfg_len8 = 1'b1;
    logic [1:0] cfg_parity = 2'b00;
    logic       baud_tick = 1'b0;
    logic       cts = 1'b1;
    logic       xoff_seen = 1'b0;
    logic       xon_seen = 1'b0;
    logic       tx_line;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int tdiv  = 0;

    always #2.5 clk = ~clk;

    // Baud tick: one cycle high in every four
    always @(negedge clk) begin
        tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == 3);
    end

    uart_tx_flow dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .cfg_len8   (cfg_len8),
        .cfg_parity (cfg_parity),
        .baud_tick  (baud_tick),
        .cts        (cts),
        .xoff_seen  (xoff_seen),
        .xon_seen   (xon_seen),
        .tx_line    (tx_line)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected frame, bit 0 of the vector is the first bit on the line
    function automatic logic [11:0] mkframe(input logic [7:0] d, input logic len8,
                                            input logic [1:0] par, output int nb);
        logic [11:0] v = '0;
        int n = len8 ? 8 : 7;
        int ones = 0;
        int p = 1;
        v[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            v[p] = d[i];
            ones += d[i];
            p++;
        end
        if (par == 2'b01) begin
            v[p] = ((ones % 2) == 0);
            p++;
        end else if (par == 2'b10) begin
            v[p] = ((ones % 2) == 1);
            p++;
        end
        v[p] = 1'b1;
        nb = p + 1;
        return v;
    endfunction

    // Called just after the accepting edge; samples bit centres and ready timing
    task automatic grab(input logic [11:0] exp, input int nb, input string req,
                        input int midop, input logic exp_rdy);
        logic [11:0] got = '0;
        int  tk = 0;
        bit  mid_done = 0;
        logic r_pre, r_end;
        for (int b = 0; b <= nb + 1; b++) begin
            int target;
            if (b < nb) target = 16 * b + 8;
            else if (b == nb) target = 16 * nb - 1;
            else target = 16 * nb;
            while (tk < target) begin
                @(posedge clk);
                if (baud_tick) tk++;
                #1;
                if (xoff_seen) xoff_seen = 1'b0;
                if (tk == 20 && !mid_done) begin
                    mid_done = 1;
                    case (midop)
                        1: cts = 1'b0;
                        2: xoff_seen = 1'b1;
                        3: begin
                            cfg_len8   = ~cfg_len8;
                            cfg_parity = 2'b01;
                            in_data    = 8'hFF;
                        end
                        default: ;
                    endcase
                end
            end
            if (b < nb) got[b] = tx_line;
            else if (b == nb) r_pre = in_ready;
            else r_end = in_ready;
        end
        chk(got == exp, req, "frame bits", int'(got), int'(exp));
        chk(r_pre == 1'b0 && r_end == exp_rdy, "R6", "ready at frame end",
            {r_pre, r_end}, {1'b0, exp_rdy});
    endtask

    task automatic send(input logic [7:0] d, input logic len8, input logic [1:0] par,
                        input string req, input int midop, input logic exp_rdy,
                        input bit pause_with);
        logic [11:0] exp;
        int nb;
        exp = mkframe(d, len8, par, nb);
        @(negedge clk);
        in_data    = d;
        cfg_len8   = len8;
        cfg_parity = par;
        in_valid   = 1'b1;
        if (pause_with) xoff_seen = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid  = 1'b0;
        xoff_seen = 1'b0;
        grab(exp, nb, req, midop, exp_rdy);
    endtask

    // Offer a byte while blocked, check nothing starts, then release
    task automatic blocked_then_release(input logic [7:0] d, input int how, input string req);
        logic [11:0] exp;
        int nb;
        bit quiet = 1;
        exp = mkframe(d, 1'b1, 2'b00, nb);
        @(negedge clk);
        in_data    = d;
        cfg_len8   = 1'b1;
        cfg_parity = 2'b00;
        in_valid   = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tx_line !== 1'b1 || in_ready !== 1'b0) quiet = 0;
        end
        chk(quiet, req, "held off while blocked", quiet, 1);
        if (how == 0) begin
            cts = 1'b1;
        end else begin
            xon_seen = 1'b1;
            @(negedge clk);
            xon_seen = 1'b0;
        end
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        grab(exp, nb, req, 0, 1'b1);
    endtask

    task automatic pulse(input bit off, input bit on);
        @(negedge clk);
        xoff_seen = off;
        xon_seen  = on;
        @(negedge clk);
        xoff_seen = 1'b0;
        xon_seen  = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(tx_line == 1'b1, "R1", "line after reset", tx_line, 1);
        chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    endtask

    task automatic t_plain_frames();
        send(8'h55, 1'b1, 2'b00, "R2", 0, 1'b1, 0);
        send(8'hA3, 1'b1, 2'b00, "R2", 0, 1'b1, 0);
        send(8'h00, 1'b1, 2'b00, "R2", 0, 1'b1, 0);
        send(8'hFF, 1'b1, 2'b00, "R2", 0, 1'b1, 0);
    endtask

    task automatic t_short_len();
        send(8'hC5, 1'b0, 2'b00, "R3", 0, 1'b1, 0);
        send(8'h80, 1'b0, 2'b10, "R3", 0, 1'b1, 0);
    endtask

    task automatic t_parity();
        send(8'hA3, 1'b1, 2'b01, "R4", 0, 1'b1, 0);
        send(8'hA3, 1'b1, 2'b10, "R4", 0, 1'b1, 0);
        send(8'h07, 1'b0, 2'b01, "R4", 0, 1'b1, 0);
        send(8'h01, 1'b1, 2'b10, "R4", 0, 1'b1, 0);
        send(8'h3C, 1'b1, 2'b11, "R4", 0, 1'b1, 0);
    endtask

    task automatic t_cfg_hold();
        send(8'h4B, 1'b0, 2'b00, "R5", 3, 1'b1, 0);
    endtask

    task automatic t_cts_block();
        cts = 1'b0;
        blocked_then_release(8'h96, 0, "R7");
    endtask

    task automatic t_cts_midframe();
        send(8'h69, 1'b1, 2'b10, "R9", 1, 1'b0, 0);
        @(negedge clk);
        chk(in_ready == 1'b0 && tx_line == 1'b1, "R10", "idle, cts low",
            {in_ready, tx_line}, 2'b01);
        cts = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R10", "ready after cts returns", in_ready, 1);
    endtask

    task automatic t_xoff_xon();
        pulse(1'b1, 1'b0);
        chk(in_ready == 1'b0, "R8", "ready after xoff", in_ready, 0);
        blocked_then_release(8'h2D, 1, "R8");
    endtask

    task automatic t_xoff_midframe();
        send(8'hE1, 1'b1, 2'b01, "R9", 2, 1'b0, 0);
        pulse(1'b0, 1'b1);
        chk(in_ready == 1'b1, "R8", "ready after xon", in_ready, 1);
    endtask

    task automatic t_both_same_cycle();
        pulse(1'b1, 1'b1);
        chk(in_ready == 1'b0, "R8", "pause wins over resume", in_ready, 0);
        blocked_then_release(8'h5A, 1, "R8");
    endtask

    task automatic t_pause_on_accept();
        send(8'hB7, 1'b1, 2'b00, "R9", 0, 1'b0, 1);
        pulse(1'b0, 1'b1);
        chk(in_ready == 1'b1, "R10", "ready after resume", in_ready, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain_frames();
        t_short_len();
        t_parity();
        t_cfg_hold();
        t_cts_block();
        t_cts_midframe();
        t_xoff_xon();
        t_xoff_midframe();
        t_both_same_cycle();
        t_pause_on_accept();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog run did not end actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule